// File: doc/BRIEF.md
# Gated IF Frequency Counter with Open-Drain Status Output

This block measures an intermediate-frequency signal by counting its edges over a timed window. A software-controlled enable bit arms the counter. Its rising edge starts a fixed settling wait, which is followed by a measurement window of 4, 8, 16 or 32 ms chosen by a 2-bit select. Both durations come from counting ticks of the 75 kHz crystal reference. The edge count saturates instead of wrapping. When the window closes, the count and a completion flag stay in place until the enable bit is dropped, so the value can be read out through the serial frame.

The same block owns the pull-down of the shared open-drain status line. A 3-bit selector routes one condition onto that line: PLL unlock, end of count, signal-detect active or stereo active. Every other selector code leaves the line released. The line is always released while the serial chip-enable is high. The PLL unlock detector is built in as well. It can be switched off, can pass the raw phase-error signal through, or can flag phase errors that exceed the lock window, stretching the flag by a programmed number of crystal ticks.

Top module: `ifc_counter_top`

## Requirements
- R1: While `start_en` is 0, `count` is held at 0 and `count_done` is 0.
- R2: A 0-to-1 change of `start_en` begins a settling wait of `WAIT_TICKS` crystal ticks (default 263). No IF edges are counted during the wait.
- R3: After the wait, the measurement window lasts `GATE_BASE << gate_sel` crystal ticks (default base 300, giving 4/8/16/32 ms at 75 kHz). `count_done` rises at the end of the window.
- R4: During the window, each clock cycle in which `if_edge` is 1 adds one to `count`.
- R5: `count` saturates at 2^CNT_W−1 and does not wrap.
- R6: After completion, `count` and `count_done` stay unchanged until `start_en` returns to 0. A new measurement needs a fresh 0-to-1 change of `start_en`.
- R7: `do_low` follows `do_sel`: 3'b001 gives unlock (`!locked`), 3'b101 gives `sd_active`, and 3'b110 gives `stereo_active`. All other codes except 3'b010 give 0. At reset `do_low` is 0.
- R8: With `do_sel` = 3'b010, `do_low` is 0 from the start of a measurement and becomes 1 once the measurement is complete.
- R9: While `ce` is 1, `do_low` is 0 whatever the selector and flags.
- R10: With `ul_sel` = 2'b00, unlock detection is stopped and `locked` is 1.
- R11: With `ul_sel` = 2'b01, `locked` is the inverse of `phase_err`.
- R12: With `ul_sel[1]` = 1, a cycle with `phase_err_big` makes `locked` 0 from the next cycle. `locked` stays 0 until `STRETCH_TICKS` further crystal ticks have passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xtal_tick | input | 1 | One-cycle strobe per crystal reference period |
| if_edge | input | 1 | One-cycle strobe per IF input edge |
| start_en | input | 1 | Counter enable: 0 holds reset, rising edge starts |
| gate_sel | input | 2 | Window select (base shifted left by this value) |
| ce | input | 1 | Serial chip-enable; 1 releases the status line |
| do_sel | input | 3 | Status line source select |
| ul_sel | input | 2 | Unlock detector mode |
| phase_err | input | 1 | Raw phase-comparator error |
| phase_err_big | input | 1 | Phase error outside the lock window |
| sd_active | input | 1 | Signal detect active |
| stereo_active | input | 1 | Stereo pilot detected |
| count | output | CNT_W | Edge count (LSB at bit 0) |
| count_done | output | 1 | Measurement complete |
| locked | output | 1 | 1 when locked or detection stopped, 0 at unlock |
| do_low | output | 1 | 1 pulls the open-drain status line low |

## Verification
The case that needs most care is the completion flag and the chip-enable release landing on the status line together. The bench raises `ce` in the cycle after `count_done` has driven `do_low` high, and `do_low` must go back to 0 with the held count untouched. A second overlap is the last IF edge of the window arriving on the same clock edge that ends the window. Each IF strobe period divides the tick period, so the expected count is an exact product and any lost or extra edge at the window boundary shows up. Saturation is provoked by a window that is longer in edges than the counter can hold.

// File: rtl/ifc_pkg.sv
package ifc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_GATE = 2'd2,
    ST_DONE = 2'd3
  } seq_state_t;

  localparam logic [2:0] DOSEL_UNLOCK = 3'b001;
  localparam logic [2:0] DOSEL_EOC    = 3'b010;
  localparam logic [2:0] DOSEL_SD     = 3'b101;
  localparam logic [2:0] DOSEL_STEREO = 3'b110;

endpackage

// File: rtl/ifc_gate_seq.sv
module ifc_gate_seq
  import ifc_pkg::*;
#(
  parameter int WAIT_TICKS = 263,
  parameter int GATE_BASE  = 300
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xtal_tick,
  input  logic       start_en,
  input  logic [1:0] gate_sel,
  output logic       gate_open,
  output logic       cnt_clr,
  output logic       done
);

  localparam int TICK_W = $clog2(GATE_BASE * 8 + WAIT_TICKS + 1);
  localparam logic [TICK_W-1:0] WAIT_LAST = TICK_W'(WAIT_TICKS - 1);
  localparam logic [TICK_W-1:0] BASE_V    = TICK_W'(GATE_BASE);

  seq_state_t        state_q, state_d;
  logic [TICK_W-1:0] tcnt_q, tcnt_d;
  logic [1:0]        gt_q, gt_d;
  logic              en_q;
  logic              start_pulse;
  logic [TICK_W-1:0] gate_last;

  assign start_pulse = start_en & ~en_q;
  assign gate_last   = (BASE_V << gt_q) - TICK_W'(1);

  always_comb begin
    state_d = state_q;
    tcnt_d  = tcnt_q;
    gt_d    = gt_q;
    if (!start_en) begin
      state_d = ST_IDLE;
      tcnt_d  = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_pulse) begin
            state_d = ST_WAIT;
            tcnt_d  = '0;
            gt_d    = gate_sel;
          end
        end
        ST_WAIT: begin
          if (xtal_tick) begin
            if (tcnt_q == WAIT_LAST) begin
              state_d = ST_GATE;
              tcnt_d  = '0;
            end else begin
              tcnt_d = tcnt_q + TICK_W'(1);
            end
          end
        end
        ST_GATE: begin
          if (xtal_tick) begin
            if (tcnt_q == gate_last) begin
              state_d = ST_DONE;
              tcnt_d  = '0;
            end else begin
              tcnt_d = tcnt_q + TICK_W'(1);
            end
          end
        end
        ST_DONE: begin
          state_d = ST_DONE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tcnt_q  <= '0;
      gt_q    <= '0;
      en_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      tcnt_q  <= tcnt_d;
      gt_q    <= gt_d;
      en_q    <= start_en;
    end
  end

  assign gate_open = (state_q == ST_GATE);
  assign cnt_clr   = (state_q == ST_IDLE);
  assign done      = (state_q == ST_DONE);

  // R3: the window tick counter never passes the selected window length
  assert_window_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_GATE) |-> (tcnt_q <= gate_last));

  // R1: a low enable returns the sequencer to idle
  assert_idle_on_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !start_en |=> (state_q == ST_IDLE));

  // R2: the wait always precedes the window
  assert_wait_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |=> (state_q != ST_GATE));

endmodule

// File: rtl/ifc_sat_counter.sv
module ifc_sat_counter #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = clr | (inc & (cnt_q != CNT_MAX));

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R5: a full counter stays full until cleared
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q == CNT_MAX) && !clr) |=> (cnt_q == CNT_MAX));

  // R4: the count changes only on a counted edge or a clear
  assert_quiet_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(cnt_q));

endmodule

// File: rtl/ifc_unlock_det.sv
module ifc_unlock_det #(
  parameter int STRETCH_TICKS = 113
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xtal_tick,
  input  logic [1:0] ul_sel,
  input  logic       phase_err,
  input  logic       phase_err_big,
  output logic       locked
);

  localparam int SW = $clog2(STRETCH_TICKS + 1);
  localparam logic [SW-1:0] STRETCH_V = SW'(STRETCH_TICKS);

  logic [SW-1:0] hold_q, hold_d;

  always_comb begin
    hold_d = hold_q;
    if (!ul_sel[1])                       hold_d = '0;
    else if (phase_err_big)               hold_d = STRETCH_V;
    else if (xtal_tick && hold_q != '0)   hold_d = hold_q - SW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  always_comb begin
    unique case (ul_sel)
      2'b00:   locked = 1'b1;
      2'b01:   locked = ~phase_err;
      default: locked = (hold_q == '0);
    endcase
  end

  // R12: a wide phase error shows as unlock in the following cycle
  assert_stretch_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ul_sel[1] && phase_err_big) |=> (hold_q != '0));

  // R12: the stretch counter never exceeds its programmed length
  assert_stretch_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q <= STRETCH_V);

endmodule

// File: rtl/ifc_counter_top.sv
module ifc_counter_top
  import ifc_pkg::*;
#(
  parameter int CNT_W         = 20,
  parameter int WAIT_TICKS    = 263,
  parameter int GATE_BASE     = 300,
  parameter int STRETCH_TICKS = 113
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xtal_tick,
  input  logic             if_edge,
  input  logic             start_en,
  input  logic [1:0]       gate_sel,
  input  logic             ce,
  input  logic [2:0]       do_sel,
  input  logic [1:0]       ul_sel,
  input  logic             phase_err,
  input  logic             phase_err_big,
  input  logic             sd_active,
  input  logic             stereo_active,
  output logic [CNT_W-1:0] count,
  output logic             count_done,
  output logic             locked,
  output logic             do_low
);

  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  logic       gate_open;
  logic       cnt_clr;
  logic       seq_done;
  logic       lock_flag;
  logic       do_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  ifc_gate_seq #(
    .WAIT_TICKS (WAIT_TICKS),
    .GATE_BASE  (GATE_BASE)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .xtal_tick (xtal_tick),
    .start_en  (start_en),
    .gate_sel  (gate_sel),
    .gate_open (gate_open),
    .cnt_clr   (cnt_clr),
    .done      (seq_done)
  );

  ifc_sat_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (cnt_clr),
    .inc   (gate_open & if_edge),
    .count (count)
  );

  ifc_unlock_det #(
    .STRETCH_TICKS (STRETCH_TICKS)
  ) u_ul (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .xtal_tick     (xtal_tick),
    .ul_sel        (ul_sel),
    .phase_err     (phase_err),
    .phase_err_big (phase_err_big),
    .locked        (lock_flag)
  );

  assign locked     = lock_flag;
  assign count_done = seq_done;

  always_comb begin
    unique case (do_sel)
      DOSEL_UNLOCK: do_src = ~lock_flag;
      DOSEL_EOC:    do_src = seq_done;
      DOSEL_SD:     do_src = sd_active;
      DOSEL_STEREO: do_src = stereo_active;
      default:      do_src = 1'b0;
    endcase
  end

  assign do_low = do_src & ~ce & rst_sync_n;

  // R9: chip-enable high always releases the status line
  assert_ce_release_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ce |-> !do_low);

  // R8: a new start clears the completion flag
  assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(start_en) |=> !count_done);

  // R6: the result holds while the enable stays high
  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (count_done && start_en) |=> ($stable(count) && count_done));

endmodule

// File: tb/sim_ifc_counter_top.sv
module sim_ifc_counter_top;

  localparam int CW = 6;
  localparam int WT = 3;
  localparam int GB = 2;
  localparam int ST = 5;
  localparam int K  = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          xtal_tick;
  logic          if_edge;
  logic          start_en;
  logic [1:0]    gate_sel;
  logic          ce;
  logic [2:0]    do_sel;
  logic [1:0]    ul_sel;
  logic          phase_err;
  logic          phase_err_big;
  logic          sd_active;
  logic          stereo_active;
  logic [CW-1:0] count;
  logic          count_done;
  logic          locked;
  logic          do_low;

  int n_chk  = 0;
  int n_fail = 0;
  int div_q  = 0;
  int ifc_q  = 0;
  int if_per = 1;

  always #2.5 clk = ~clk;

  ifc_counter_top #(
    .CNT_W (CW), .WAIT_TICKS (WT), .GATE_BASE (GB), .STRETCH_TICKS (ST)
  ) u0 (
    .clk (clk), .rst_n (rst_n), .xtal_tick (xtal_tick), .if_edge (if_edge),
    .start_en (start_en), .gate_sel (gate_sel), .ce (ce), .do_sel (do_sel),
    .ul_sel (ul_sel), .phase_err (phase_err), .phase_err_big (phase_err_big),
    .sd_active (sd_active), .stereo_active (stereo_active),
    .count (count), .count_done (count_done), .locked (locked), .do_low (do_low)
  );

  always @(posedge clk) begin
    div_q     <= (div_q + 1) % K;
    ifc_q     <= ifc_q + 1;
    xtal_tick <= (div_q == K - 1);
    if_edge   <= ((ifc_q % if_per) == 0);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic measure(input int gt, input int per);
    int len_cyc;
    int exp;
    int elapsed;
    int lo;
    int hi;
    start_en = 1'b0;
    do_sel   = 3'b010;
    ce       = 1'b0;
    repeat (3) @(negedge clk);
    check(count == 0 && !count_done, "R1", int'(count), 0);
    gate_sel = 2'(gt);
    if_per   = per;
    repeat (2) @(negedge clk);
    start_en = 1'b1;
    len_cyc  = (GB << gt) * K;
    exp      = len_cyc / per;
    if (exp > CMAX) exp = CMAX;
    elapsed  = 0;
    repeat (8) begin @(negedge clk); elapsed++; end
    check(count == 0, "R2", int'(count), 0);
    check(do_low == 1'b0, "R8", int'(do_low), 0);
    while (!count_done && elapsed < 2000) begin @(negedge clk); elapsed++; end
    lo = (WT + (GB << gt)) * K - 4;
    hi = (WT + (GB << gt)) * K + 1;
    check(elapsed >= lo && elapsed <= hi, "R3", elapsed, hi);
    if (exp == CMAX) check(count == CW'(exp), "R5", int'(count), exp);
    else             check(count == CW'(exp), "R4", int'(count), exp);
    check(do_low == 1'b1, "R8", int'(do_low), 1);
    ce = 1'b1;
    @(negedge clk);
    check(do_low == 1'b0, "R9", int'(do_low), 0);
    ce = 1'b0;
    repeat (20) @(negedge clk);
    check(count == CW'(exp) && count_done, "R6", int'(count), exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start_en = 1'b0; gate_sel = 2'b00; ce = 1'b0;
    do_sel = 3'b010; ul_sel = 2'b00; phase_err = 1'b0; phase_err_big = 1'b0;
    sd_active = 1'b0; stereo_active = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(count == 0 && !count_done, "R1 reset", int'(count), 0);
    check(do_low == 1'b0, "R7 reset", int'(do_low), 0);
    check(locked == 1'b1, "R10 reset", int'(locked), 1);

    for (int gt = 0; gt < 4; gt++)
      for (int pi = 0; pi < 3; pi++)
        measure(gt, 1 << pi);

    // R6: no restart without a fresh rising edge, even with a new gate select
    gate_sel = 2'b00;
    repeat (40) @(negedge clk);
    check(count_done == 1'b1, "R6 norestart", int'(count_done), 1);

    // R7, R9, R11: exhaustive selector sweep
    start_en = 1'b0;
    ul_sel   = 2'b01;
    repeat (3) @(negedge clk);
    for (int c = 0; c < 8; c++)
      for (int v = 0; v < 16; v++) begin
        int e;
        do_sel        = 3'(c);
        phase_err     = v[0];
        sd_active     = v[1];
        stereo_active = v[2];
        ce            = v[3];
        @(negedge clk);
        case (c)
          1: e = v[0];
          5: e = v[1];
          6: e = v[2];
          default: e = 0;
        endcase
        if (v[3]) begin
          e = 0;
          check(do_low == 1'(e), "R9", int'(do_low), e);
        end else begin
          check(do_low == 1'(e), "R7", int'(do_low), e);
        end
        check(locked == !v[0], "R11", int'(locked), int'(!v[0]));
      end
    ce = 1'b0; phase_err = 1'b0;

    // R10: stopped detector ignores wide errors
    ul_sel = 2'b00;
    phase_err_big = 1'b1;
    @(negedge clk);
    phase_err_big = 1'b0;
    repeat (2) @(negedge clk);
    check(locked == 1'b1, "R10", int'(locked), 1);

    // R12: stretched unlock
    ul_sel = 2'b10;
    do_sel = 3'b001;
    repeat (2) @(negedge clk);
    check(locked == 1'b1, "R12 idle", int'(locked), 1);
    phase_err_big = 1'b1;
    @(negedge clk);
    phase_err_big = 1'b0;
    check(locked == 1'b0 && do_low == 1'b1, "R12 rise", int'(locked), 0);
    repeat (15) @(negedge clk);
    check(locked == 1'b0, "R12 held", int'(locked), 0);
    repeat (5) @(negedge clk);
    check(locked == 1'b1, "R12 end", int'(locked), 1);

    finish_run();
  end

endmodule